// File: doc/BRIEF.md
# Calibrated Sensor Code / Temperature Converter

This block maps a 12-bit thermal sensor reading to a temperature in millidegrees Celsius. It uses a two-point linear calibration. Two trim codes give the sensor outputs at the low and the high calibration points, and those points sit at fixed temperatures of −41 °C and +126 °C. The same block also runs the mapping backwards. It turns a millidegree threshold into the sensor code that a window comparator elsewhere on the chip would compare against.

A request is a single-cycle `start` pulse. `dir_sel` picks the direction on that same cycle. The block first checks the two trim codes. If they cannot describe a line, it raises `err` for one cycle and produces nothing. Otherwise it runs a signed shift-subtract divider that resolves one quotient bit per clock. It then applies the ±41/×1000 scaling and clamps the result, and pulses `done` when the result is on the output.

Both results are held on their outputs until the next successful conversion in the same direction.

Top module: `temp_code_conv`

## Requirements
- R1: In forward mode (`dir_sel`=0) the block computes the whole-degree quotient q = 167·(a − b) / (c − b), truncated toward zero. Here a is `code_in` and b, c are the trim codes. It then returns (q − 41)·1000 on `temp_out` as a signed 32-bit value.
- R2: The forward result is clamped to the range −40000 to 125000 inclusive.
- R3: In inverse mode (`dir_sel`=1), `temp_in` is first truncated toward zero to whole degrees t. The quotient q = (t + 41)·(c − b) / 167 is then truncated toward zero, and q + b is returned on `code_out`.
- R4: The inverse result is clamped to the range 0 to 4095.
- R5: Only bits 11:0 of `trim_b_word` and of `trim_c_word` are used as b and c. All higher bits are ignored.
- R6: A request with invalid calibration gives a one-cycle `err` pulse on the cycle after the request is sampled, with no `done` and no change on either result output. Calibration is invalid when b = 0, c = 0, b = 4095, c = 4095 or b = c.
- R7: After an accepted request, `busy` is high from the next cycle until the cycle `done` pulses, and `done` lasts one cycle. A `start` seen while `busy` is high is ignored.
- R8: After reset, `busy`, `done` and `err` are low and both result outputs are zero.
- R9: Counting from the edge that samples `start`, `done` is seen after DIV_W+1 edges for a forward conversion and after 2·DIV_W+2 edges for an inverse one.
- R10: A completed conversion updates only the output of its own direction. The other output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled when idle |
| dir_sel | input | 1 | 0: code to temperature, 1: temperature to code |
| code_in | input | 12 | Sensor code for forward mode |
| temp_in | input | 32 | Signed millidegree input for inverse mode |
| trim_b_word | input | 32 | Word holding low-point trim code in bits 11:0 |
| trim_c_word | input | 32 | Word holding high-point trim code in bits 11:0 |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle invalid-calibration pulse |
| temp_out | output | 32 | Signed millidegree result, clamped |
| code_out | output | 12 | Sensor code result, clamped |

## Verification
A divider that drops or repeats an iteration shows up at the ports in two ways. The `done` pulse lands off its fixed edge count, and the result drifts by a power of two, so the latency check and every value check both catch it on the first request. A wrong quotient sign or a floor-instead-of-truncate rounding shows on the first inverse request with a negative, non-integral input. A stale trim register or a missed validity case shows on the next request: the result is wrong, or `err` appears where `done` was due.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int CODE_W = 12;
  localparam int TEMP_W = 32;
  localparam int CALC_W = 40;
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int LO_DEG = -41;
  localparam int HI_DEG = 126;
  localparam int MILLI = 1000;
  localparam int T_MIN_MC = -40000;
  localparam int T_MAX_MC = 125000;

  typedef logic signed [CALC_W-1:0] calc_t;

  localparam calc_t K_SPAN  = calc_t'(HI_DEG - LO_DEG);
  localparam calc_t K_OFS   = calc_t'(-LO_DEG);
  localparam calc_t K_MILLI = calc_t'(MILLI);

  function automatic calc_t ext_code(input logic [CODE_W-1:0] v);
    return calc_t'({{(CALC_W-CODE_W){1'b0}}, v});
  endfunction

  function automatic calc_t ext_temp(input logic signed [TEMP_W-1:0] v);
    return calc_t'(v);
  endfunction

  function automatic logic trim_valid(input logic [CODE_W-1:0] b,
                                      input logic [CODE_W-1:0] c);
    logic bad;
    bad = (b == '0) || (c == '0) || (b == CODE_W'(CODE_MAX)) ||
          (c == CODE_W'(CODE_MAX)) || (b == c);
    return !bad;
  endfunction

  // whole-degree quotient -> clamped millidegrees
  function automatic logic signed [TEMP_W-1:0] fwd_finish(input calc_t q);
    calc_t t;
    t = (q - K_OFS) * K_MILLI;
    if (t < calc_t'(T_MIN_MC)) t = calc_t'(T_MIN_MC);
    if (t > calc_t'(T_MAX_MC)) t = calc_t'(T_MAX_MC);
    return t[TEMP_W-1:0];
  endfunction

  // code quotient plus low trim -> clamped sensor code
  function automatic logic [CODE_W-1:0] inv_finish(input calc_t q,
                                                   input logic [CODE_W-1:0] b);
    calc_t v;
    v = q + ext_code(b);
    if (v < 0) v = '0;
    if (v > calc_t'(CODE_MAX)) v = calc_t'(CODE_MAX);
    return v[CODE_W-1:0];
  endfunction
endpackage

// File: rtl/tcc_trim_check.sv
module tcc_trim_check #(
  parameter int CW = 12,
  parameter int WW = 32
) (
  input  logic [WW-1:0] b_word,
  input  logic [WW-1:0] c_word,
  output logic [CW-1:0] b_code,
  output logic [CW-1:0] c_code,
  output logic          ok
);
  assign b_code = b_word[CW-1:0];
  assign c_code = c_word[CW-1:0];
  assign ok     = tcc_pkg::trim_valid(b_code, c_code);
endmodule

// File: rtl/tcc_divider.sv
module tcc_divider #(
  parameter int W = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic signed [W-1:0] num,
  input  logic signed [W-1:0] den,
  output logic                fin,
  output logic signed [W-1:0] quot
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q, quo_q, dv_q;
  logic             neg_q, run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W:0]       shifted, diff;
  logic             take;

  function automatic logic [W-1:0] mag(input logic signed [W-1:0] v);
    return v[W-1] ? W'(-v) : W'(v);
  endfunction

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    diff    = shifted - {1'b0, dv_q};
    take    = !diff[W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0; quo_q <= '0; dv_q <= '0;
      neg_q <= 1'b0; run_q <= 1'b0; cnt_q <= '0; fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        rem_q <= '0;
        quo_q <= mag(num);
        dv_q  <= mag(den);
        neg_q <= num[W-1] ^ den[W-1];
        cnt_q <= CNT_W'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= take ? diff[W-1:0] : shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], take};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q <= 1'b0;
          fin   <= 1'b1;
        end
      end
    end
  end

  assign quot = neg_q ? -$signed(quo_q) : $signed(quo_q);
endmodule

// File: rtl/temp_code_conv.sv
module temp_code_conv
  import tcc_pkg::*;
#(
  parameter int DIV_W = tcc_pkg::CALC_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     dir_sel,
  input  logic [CODE_W-1:0]        code_in,
  input  logic signed [TEMP_W-1:0] temp_in,
  input  logic [TEMP_W-1:0]        trim_b_word,
  input  logic [TEMP_W-1:0]        trim_c_word,
  output logic                     busy,
  output logic                     done,
  output logic                     err,
  output logic signed [TEMP_W-1:0] temp_out,
  output logic [CODE_W-1:0]        code_out
);
  typedef enum logic [1:0] {ST_IDLE, ST_SCALE, ST_FINAL} st_t;

  st_t               st;
  logic              mode_inv;
  logic [CODE_W-1:0] b_r, c_r, b_w, c_w;
  logic              trim_ok, accept;
  logic              div_go, div_fin;
  calc_t             div_num, div_den, div_quot;

  tcc_trim_check #(.CW(CODE_W), .WW(TEMP_W)) u_trim (
    .b_word(trim_b_word), .c_word(trim_c_word),
    .b_code(b_w), .c_code(c_w), .ok(trim_ok)
  );

  tcc_divider #(.W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go),
    .num(div_num), .den(div_den), .fin(div_fin), .quot(div_quot)
  );

  assign accept = start && (st == ST_IDLE);

  always_comb begin
    div_go  = 1'b0;
    div_num = '0;
    div_den = '0;
    if (accept && trim_ok) begin
      div_go = 1'b1;
      if (!dir_sel) begin
        div_num = K_SPAN * (ext_code(code_in) - ext_code(b_w));
        div_den = ext_code(c_w) - ext_code(b_w);
      end else begin
        div_num = ext_temp(temp_in);
        div_den = K_MILLI;
      end
    end else if (st == ST_SCALE && div_fin) begin
      div_go  = 1'b1;
      div_num = (div_quot + K_OFS) * (ext_code(c_r) - ext_code(b_r));
      div_den = K_SPAN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; mode_inv <= 1'b0; b_r <= '0; c_r <= '0;
      done <= 1'b0; err <= 1'b0; temp_out <= '0; code_out <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          if (trim_ok) begin
            b_r      <= b_w;
            c_r      <= c_w;
            mode_inv <= dir_sel;
            st       <= dir_sel ? ST_SCALE : ST_FINAL;
          end else begin
            err <= 1'b1;
          end
        end
        ST_SCALE: if (div_fin) st <= ST_FINAL;
        ST_FINAL: if (div_fin) begin
          done <= 1'b1;
          st   <= ST_IDLE;
          if (mode_inv) code_out <= inv_finish(div_quot, b_r);
          else          temp_out <= fwd_finish(div_quot);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st != ST_IDLE);
endmodule

// File: rtl/tcc_checker.sv
module tcc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        trim_ok,
  input logic        div_fin,
  input logic [31:0] temp_out,
  input logic [11:0] code_out
);
  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && trim_ok) |=> busy);

  a_r6_err_on_bad_trim: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !trim_ok) |=> (err && !busy && !done));

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !err));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_temp_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($signed(temp_out) >= -40000 && $signed(temp_out) <= 125000));

  a_r10_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(temp_out) && $stable(code_out)));

  a_r9_div_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    div_fin |-> busy);
endmodule

bind temp_code_conv tcc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .trim_ok(trim_ok), .div_fin(div_fin),
  .temp_out(temp_out), .code_out(code_out)
);

// File: tb/sim_temp_code_conv.sv
module sim_temp_code_conv;
  localparam int DW = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dir_sel = 1'b0;
  logic [11:0] code_in = '0;
  logic [31:0] temp_in = '0;
  logic [31:0] trim_b_word = '0;
  logic [31:0] trim_c_word = '0;
  logic        busy, done, err;
  logic [31:0] temp_out;
  logic [11:0] code_out;

  int n_run = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  temp_code_conv #(.DIV_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_sel(dir_sel),
    .code_in(code_in), .temp_in(temp_in), .trim_b_word(trim_b_word),
    .trim_c_word(trim_c_word), .busy(busy), .done(done), .err(err),
    .temp_out(temp_out), .code_out(code_out)
  );

  initial begin
    #800000;
    n_run++; n_bad++;
    $display("FAIL watchdog: run hung, actual no finish, expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  function automatic longint exp_fwd(int a, int b, int c);
    longint q, t;
    q = (longint'(167) * longint'(a - b)) / longint'(c - b);
    t = (q - 41) * 1000;
    if (t < -40000) t = -40000;
    if (t > 125000) t = 125000;
    return t;
  endfunction

  function automatic longint exp_inv(int t_mc, int b, int c);
    longint tc, q, v;
    tc = longint'(t_mc) / 1000;
    q  = ((tc + 41) * longint'(c - b)) / 167;
    v  = q + b;
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  function automatic bit trims_ok(int b, int c);
    return !(b == 0 || c == 0 || b == 4095 || c == 4095 || b == c);
  endfunction

  task automatic check(string req, longint act, longint expv);
    n_run++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // issue one request; returns edges counted until done/err
  task automatic issue(bit d, int code, int tmp, logic [31:0] bw,
                       logic [31:0] cw, output int edges);
    @(negedge clk);
    dir_sel = d; code_in = code[11:0]; temp_in = tmp;
    trim_b_word = bw; trim_c_word = cw; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    edges = 0;
    while (!done && !err && edges < 4 * DW) begin
      @(posedge clk);
      @(negedge clk);
      edges++;
    end
  endtask

  task automatic run_fwd(int a, logic [31:0] bw, logic [31:0] cw, string req);
    int e;
    logic [11:0] code_before;
    code_before = code_out;
    issue(1'b0, a, 0, bw, cw, e);
    check({req, "/R1 fwd value"}, longint'($signed(temp_out)),
          exp_fwd(a, int'(bw[11:0]), int'(cw[11:0])));
    check("R9 fwd latency", e, DW + 1);
    check("R10 code held", code_out, code_before);
  endtask

  task automatic run_inv(int t, logic [31:0] bw, logic [31:0] cw, string req);
    int e;
    logic [31:0] temp_before;
    temp_before = temp_out;
    issue(1'b1, 0, t, bw, cw, e);
    check({req, "/R3 inv value"}, code_out,
          exp_inv(t, int'(bw[11:0]), int'(cw[11:0])));
    check("R9 inv latency", e, 2 * DW + 2);
    check("R10 temp held", temp_out, temp_before);
  endtask

  task automatic run_bad(logic [31:0] bw, logic [31:0] cw, string why);
    int e;
    logic [31:0] tb4;
    logic [11:0] cb4;
    tb4 = temp_out; cb4 = code_out;
    issue(1'b0, 100, 0, bw, cw, e);
    check({"R6 err pulse ", why}, err, 1);
    check("R6 err timing", e, 0);
    @(posedge clk); @(negedge clk);
    check("R6 err one cycle", err, 0);
    check("R6 no done", done, 0);
    check("R6 temp unchanged", temp_out, tb4);
    check("R6 code unchanged", code_out, cb4);
  endtask

  initial begin
    int e, sb, sc;
    process::self().srandom(32'd20251);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 busy reset", busy, 0);
    check("R8 done reset", done, 0);
    check("R8 err reset", err, 0);
    check("R8 temp reset", temp_out, 0);
    check("R8 code reset", code_out, 0);
    rst_n = 1'b1;

    // R1 directed
    run_fwd(1500, 32'd1000, 32'd3000, "R1 mid");
    run_fwd(2345, 32'd1200, 32'd3300, "R1 trunc");
    // R2 clamps: a=b gives -41 C, a=c gives 126 C
    run_fwd(1000, 32'd1000, 32'd3000, "R2 low clamp");
    run_fwd(3000, 32'd1000, 32'd3000, "R2 high clamp");
    run_fwd(4095, 32'd3000, 32'd1000, "R2 reversed trims");
    // R3 truncation toward zero: -1999 -> -1 deg -> 1239
    run_inv(-1999, 32'd1000, 32'd2000, "R3 neg trunc");
    check("R3 neg trunc exact", code_out, 1239);
    run_inv(25999, 32'd1000, 32'd2000, "R3 pos trunc");
    // R4 clamps
    run_inv(32'sh8000_0000, 32'd1000, 32'd2000, "R4 zero clamp");
    run_inv(32'sh7fff_ffff, 32'd1000, 32'd2000, "R4 top clamp");
    // R5 upper trim bits ignored
    run_fwd(2000, 32'hABCD_E3E8, 32'h1234_5BB8, "R5 upper bits");
    run_inv(50000, 32'hFFFF_F3E8, 32'h8000_0BB8, "R5 upper bits");
    // R6 invalid calibration cases
    run_bad(32'd0, 32'd2000, "b zero");
    run_bad(32'd1000, 32'd0, "c zero");
    run_bad(32'd4095, 32'd2000, "b max");
    run_bad(32'd1000, 32'h0000_0FFF, "c max");
    run_bad(32'd1777, 32'hF000_06F1, "b equals c");
    run_bad(32'h0000_1000, 32'd2000, "R5 low bits zero");

    // R7 busy and start-while-busy ignored
    @(negedge clk);
    dir_sel = 1'b0; code_in = 12'd2000; trim_b_word = 32'd1000;
    trim_c_word = 32'd3000; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    check("R7 busy after start", busy, 1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    code_in = 12'd3900; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    e = 0;
    while (!done && e < 4 * DW) begin
      check("R7 busy until done", busy, 1);
      @(posedge clk); @(negedge clk); e++;
    end
    check("R7 done not busy", busy, 0);
    check("R7 start ignored", longint'($signed(temp_out)),
          exp_fwd(2000, 1000, 3000));
    @(posedge clk); @(negedge clk);
    check("R7 done one cycle", done, 0);
    check("R7 no second run", busy, 0);

    // random mix
    for (int i = 0; i < 300; i++) begin
      sb = int'($urandom_range(0, 4095));
      sc = int'($urandom_range(0, 4095));
      if ($urandom_range(0, 9) != 0) begin
        if (sb == 0) sb = 1;
        if (sb == 4095) sb = 4094;
        if (sc == 0 || sc == 4095 || sc == sb) sc = (sb == 2000) ? 2100 : 2000;
      end
      if (!trims_ok(sb, sc))
        run_bad({$urandom_range(0, 255), 12'h000, 12'(sb)} , 32'(sc), "random");
      else if ($urandom_range(0, 1) == 0)
        run_fwd(int'($urandom_range(0, 4095)),
                {8'($urandom), 12'h0, 12'(sb)}, 32'(sc), "R1 random");
      else
        run_inv(int'($urandom_range(0, 220000)) - 70000,
                32'(sb), {8'($urandom), 12'h0, 12'(sc)}, "R3 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule